// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple in-order processor and works out, every cycle, the address of the next instruction. From the current counter value it forms the sequential successor (counter plus one word), a relative branch destination built from the signed 16-bit displacement in the low half of the instruction word, and an absolute jump destination built from the low 26 bits of the instruction word. The decoder supplies two one-bit strobes, one for a conditional branch on equality and one for an unconditional jump. The arithmetic unit supplies a single equality flag.

The chosen address is shown combinationally on `next_pc_o` and is loaded into the counter register on the next rising clock edge. A synchronous active-high reset clears the counter to zero. Widths of the address, the displacement and the jump field are parameters, and elaboration checks reject combinations that cannot form a 32-bit style target.

Top module: `npc_unit`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: When `jump_i` is low and `branch_i` and `zero_i` are not both high, the next counter value is `pc_o + 4` (modulo 2^32).
- R3: When `branch_i` and `zero_i` are both high and `jump_i` is low, the next value is `pc_o + 4 + (sext(instr_i[15:0]) << 2)`, with `instr_i[15:0]` read as a two's-complement number.
- R4: A branch strobe with `zero_i` low, or `zero_i` high with no branch strobe, selects the sequential value of R2.
- R5: A negative displacement gives a destination below `pc_o + 4`, with correct borrow across bit 28 and with the extreme displacements 0x7FFF and 0x8000.
- R6: When `jump_i` is high, the next value is `{(pc_o + 4)[31:28], instr_i[25:0], 2'b00}`.
- R7: `jump_i` wins over a taken branch when both are requested in the same cycle.
- R8: `pc_o` changes only at a rising clock edge, and after a non-reset edge it equals the `next_pc_o` value present just before that edge.
- R9: Bits [1:0] of `pc_o` and `next_pc_o` are always 0 once out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the counter loads on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high, clears the counter |
| instr_i | input | 32 | Current instruction word; [15:0] displacement, [25:0] jump field |
| branch_i | input | 1 | Decoder strobe: conditional branch on equality |
| jump_i | input | 1 | Decoder strobe: unconditional jump |
| zero_i | input | 1 | Equality flag from the arithmetic unit |
| pc_o | output | 32 | Registered program counter |
| next_pc_o | output | 32 | Address to be loaded at the next edge |

## Verification
The counter is walked through one chained sequence in which each step starts from the address the previous step produced, so plain increments, forward and backward branches and jumps are all tried from varied starting points. Branch requests are paired with a low equality flag, and the flag is raised with no branch request, which separates a decoder that gates on both conditions from one that looks at only one. A jump issued while a taken branch is also requested tells apart the priority order, and a jump from an address whose top nibble is nonzero tells whether those bits come from the incremented counter. Displacements 0x7FFF, 0x8000 and a small negative value crossing bit 28 expose a wrong sign extension or a missing shift.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      SRC_SEQ  = 2'd0,
      SRC_BR   = 2'd1,
      SRC_JMP  = 2'd2
   } npc_src_e;
endpackage

// File: rtl/npc_inc.sv
module npc_inc #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] inc_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_BITS;

   always_comb begin
      inc_o = pc_i + STEP;
   end
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 16,
   parameter int ALIGN_BITS = 2
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [OFF_W-1:0]  disp_i,
   output logic [ADDR_W-1:0] target_o
);
   localparam int EXT_W = ADDR_W - OFF_W - ALIGN_BITS;

   logic [ADDR_W-1:0] disp_scaled;

   generate
      if (EXT_W > 0) begin : g_ext
         always_comb begin
            disp_scaled = {{EXT_W{disp_i[OFF_W-1]}}, disp_i, {ALIGN_BITS{1'b0}}};
         end
      end else begin : g_trunc
         always_comb begin
            disp_scaled = ADDR_W'({disp_i, {ALIGN_BITS{1'b0}}});
         end
      end
   endgenerate

   always_comb begin
      target_o = base_i + disp_scaled;
   end
endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
   parameter int ADDR_W     = 32,
   parameter int FIELD_W    = 26,
   parameter int ALIGN_BITS = 2
) (
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic [ADDR_W-1:0]  target_o
);
   localparam int KEEP_W = ADDR_W - FIELD_W - ALIGN_BITS;

   generate
      if (KEEP_W > 0) begin : g_region
         always_comb begin
            target_o = {base_i[ADDR_W-1 -: KEEP_W], field_i, {ALIGN_BITS{1'b0}}};
         end
      end else begin : g_flat
         always_comb begin
            target_o = {field_i, {ALIGN_BITS{1'b0}}};
         end
      end
   endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              branch_i,
   input  logic              jump_i,
   input  logic              zero_i,
   input  logic [ADDR_W-1:0] seq_i,
   input  logic [ADDR_W-1:0] br_i,
   input  logic [ADDR_W-1:0] jmp_i,
   output logic [ADDR_W-1:0] next_o
);
   npc_src_e src;

   always_comb begin
      if (jump_i) begin
         src = SRC_JMP;
      end else if (branch_i && zero_i) begin
         src = SRC_BR;
      end else begin
         src = SRC_SEQ;
      end
   end

   always_comb begin
      unique case (src)
         SRC_JMP: next_o = jmp_i;
         SRC_BR:  next_o = br_i;
         default: next_o = seq_i;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int ADDR_W     = 32,
   parameter int INSTR_W    = 32,
   parameter int OFF_W      = 16,
   parameter int FIELD_W    = 26,
   parameter int ALIGN_BITS = 2,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic               branch_i,
   input  logic               jump_i,
   input  logic               zero_i,
   output logic [ADDR_W-1:0]  pc_o,
   output logic [ADDR_W-1:0]  next_pc_o
);
   initial begin
      if (OFF_W > INSTR_W)                    $error("npc_unit: OFF_W exceeds INSTR_W");
      if (FIELD_W > INSTR_W)                  $error("npc_unit: FIELD_W exceeds INSTR_W");
      if (FIELD_W + ALIGN_BITS > ADDR_W)      $error("npc_unit: jump field too wide");
      if (OFF_W + ALIGN_BITS > ADDR_W)        $error("npc_unit: displacement too wide");
      if (RESET_PC[ALIGN_BITS-1:0] != '0)     $error("npc_unit: RESET_PC misaligned");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_seq;
   logic [ADDR_W-1:0] pc_br;
   logic [ADDR_W-1:0] pc_jmp;
   logic [ADDR_W-1:0] pc_nxt;

   npc_inc #(
      .ADDR_W     (ADDR_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_inc (
      .pc_i  (pc_q),
      .inc_o (pc_seq)
   );

   npc_branch_tgt #(
      .ADDR_W     (ADDR_W),
      .OFF_W      (OFF_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_br (
      .base_i   (pc_seq),
      .disp_i   (instr_i[OFF_W-1:0]),
      .target_o (pc_br)
   );

   npc_jump_tgt #(
      .ADDR_W     (ADDR_W),
      .FIELD_W    (FIELD_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_jmp (
      .base_i   (pc_seq),
      .field_i  (instr_i[FIELD_W-1:0]),
      .target_o (pc_jmp)
   );

   npc_select #(
      .ADDR_W (ADDR_W)
   ) u_sel (
      .branch_i (branch_i),
      .jump_i   (jump_i),
      .zero_i   (zero_i),
      .seq_i    (pc_seq),
      .br_i     (pc_br),
      .jmp_i    (pc_jmp),
      .next_o   (pc_nxt)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pc_q <= RESET_PC;
      end else begin
         pc_q <= pc_nxt;
      end
   end

   assign pc_o      = pc_q;
   assign next_pc_o = pc_nxt;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int ADDR_W     = 32,
   parameter int INSTR_W    = 32,
   parameter int OFF_W      = 16,
   parameter int FIELD_W    = 26,
   parameter int ALIGN_BITS = 2,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [INSTR_W-1:0] instr_i,
   input logic               branch_i,
   input logic               jump_i,
   input logic               zero_i,
   input logic [ADDR_W-1:0]  pc_o,
   input logic [ADDR_W-1:0]  next_pc_o
);
   localparam int KEEP_W = ADDR_W - FIELD_W - ALIGN_BITS;
   localparam int EXT_W  = ADDR_W - OFF_W - ALIGN_BITS;

   logic [ADDR_W-1:0] chk_inc;
   logic [ADDR_W-1:0] chk_disp;
   logic              chk_out_of_rst;

   assign chk_inc  = pc_o + (ADDR_W'(1) << ALIGN_BITS);
   assign chk_disp = {{EXT_W{instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0], {ALIGN_BITS{1'b0}}};

   always_ff @(posedge clk_i) begin
      chk_out_of_rst <= rst_i ? 1'b0 : 1'b1;
   end

   assert_reset_load_R1: assert property (@(posedge clk_i)
      rst_i |=> pc_o == RESET_PC);

   assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (!jump_i && !(branch_i && zero_i)) |=> pc_o == $past(chk_inc));

   assert_branch_taken_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (branch_i && zero_i && !jump_i) |=> pc_o == $past(chk_inc) + $past(chk_disp));

   assert_jump_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      jump_i |=> pc_o[ADDR_W-KEEP_W-1:ALIGN_BITS] == $past(instr_i[FIELD_W-1:0]));

   assert_jump_region_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      jump_i |=> pc_o[ADDR_W-1 -: KEEP_W] == $past(chk_inc[ADDR_W-1 -: KEEP_W]));

   assert_load_next_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> pc_o == $past(next_pc_o));

   assert_aligned_R9: assert property (@(posedge clk_i) disable iff (rst_i || !chk_out_of_rst)
      pc_o[ALIGN_BITS-1:0] == '0 && next_pc_o[ALIGN_BITS-1:0] == '0);
endmodule

bind npc_unit npc_unit_chk #(
   .ADDR_W     (ADDR_W),
   .INSTR_W    (INSTR_W),
   .OFF_W      (OFF_W),
   .FIELD_W    (FIELD_W),
   .ALIGN_BITS (ALIGN_BITS),
   .RESET_PC   (RESET_PC)
) i_npc_unit_chk (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .instr_i   (instr_i),
   .branch_i  (branch_i),
   .jump_i    (jump_i),
   .zero_i    (zero_i),
   .pc_o      (pc_o),
   .next_pc_o (next_pc_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic [31:0] instr_i = '0;
   logic        branch_i = 1'b0;
   logic        jump_i = 1'b0;
   logic        zero_i = 1'b0;
   logic [31:0] pc_o;
   logic [31:0] next_pc_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk_i = ~clk_i;

   npc_unit i_npc_unit (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .instr_i   (instr_i),
      .branch_i  (branch_i),
      .jump_i    (jump_i),
      .zero_i    (zero_i),
      .pc_o      (pc_o),
      .next_pc_o (next_pc_o)
   );

   // vector: {branch, jump, zero, instr[31:0], expected next pc[31:0]}
   localparam int NV = 11;
   localparam logic [66:0] VEC [0:NV-1] = '{
      {1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0004},  // R2 plain step
      {1'b0, 1'b1, 1'b0, 32'h03FF_FFFC, 32'h0FFF_FFF0},  // R6 jump
      {1'b1, 1'b0, 1'b1, 32'h0000_0008, 32'h1000_0014},  // R3 forward across bit 28
      {1'b0, 1'b1, 1'b0, 32'h0000_0003, 32'h1000_000C},  // R6 jump keeps top nibble 1
      {1'b1, 1'b0, 1'b0, 32'h0000_0008, 32'h1000_0010},  // R4 branch, flag low
      {1'b1, 1'b0, 1'b1, 32'h0000_FFF0, 32'h0FFF_FFD4},  // R5 backward across bit 28
      {1'b0, 1'b0, 1'b1, 32'h0000_0100, 32'h0FFF_FFD8},  // R4 flag high, no branch
      {1'b1, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0040},  // R7 jump over taken branch
      {1'b1, 1'b0, 1'b1, 32'h0000_7FFF, 32'h0002_0040},  // R3 largest positive
      {1'b1, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_0044},  // R5 most negative
      {1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0048}   // R2 step, noisy instr
   };
   string TAG [0:NV-1] = '{"R2", "R6", "R3", "R6", "R4", "R5", "R4", "R7", "R3", "R5", "R2"};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      int wd = 0;
      while (!done && wd < 20000) begin
         @(posedge clk_i);
         wd++;
      end
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (2) @(posedge clk_i);
      #1;
      check("R1 reset value", pc_o, 32'h0);
      @(negedge clk_i);
      rst_i = 1'b0;

      for (int i = 0; i < NV; i++) begin
         {branch_i, jump_i, zero_i, instr_i} = VEC[i][66:32];
         #1;
         check({TAG[i], " next_pc_o"}, next_pc_o, VEC[i][31:0]);
         check("R9 next alignment", {30'h0, next_pc_o[1:0]}, 32'h0);
         @(posedge clk_i);
         #1;
         check({TAG[i], " R8 pc_o after edge"}, pc_o, VEC[i][31:0]);
         check("R9 pc alignment", {30'h0, pc_o[1:0]}, 32'h0);
         @(negedge clk_i);
      end

      // R8: input changes between edges do not move the counter
      held = pc_o;
      jump_i   = 1'b1;
      instr_i  = 32'h0123_4567;
      #1;
      check("R8 pc_o stable mid-cycle", pc_o, held);
      branch_i = 1'b1;
      zero_i   = 1'b1;
      #1;
      check("R8 pc_o stable after more changes", pc_o, held);
      @(posedge clk_i);
      #1;
      check("R8 R6 jump load", pc_o, 32'h048D_159C);

      // R1: reset mid-run overrides a pending jump
      @(negedge clk_i);
      rst_i = 1'b1;
      @(posedge clk_i);
      #1;
      check("R1 reset overrides jump", pc_o, 32'h0);
      @(posedge clk_i);
      #1;
      check("R1 reset held", pc_o, 32'h0);
      @(negedge clk_i);
      rst_i    = 1'b0;
      jump_i   = 1'b0;
      branch_i = 1'b0;
      zero_i   = 1'b0;
      @(posedge clk_i);
      #1;
      check("R2 step after reset", pc_o, 32'h4);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule